// File: doc/BRIEF.md
# Dual-Host Mailbox Interrupt Bridge

The bridge joins two processors, a host and a network-side controller, through one block. Each side owns a simple synchronous register bus (address, write data, read data, read strobe, write strobe). Through it, each side sees a small set of single-bit mailbox registers and a window into one shared on-chip word store. A side rings the other by clearing its doorbell bit. The receiving side's interrupt output is raised only while that doorbell is low and its own enable bit is low. The receiving side can also read the doorbell level directly.

Both buses run on one clock. The network side additionally publishes a ready flag that the host can read. It also exposes a fixed 8-bit revision number. The host owns a reset bit that leaves the block as a network-side reset output, after a flop chain that re-times it. Both sides may touch the shared store in the same cycle. If they address the same word, the host is served and the network side sees a wait for that cycle and must hold its request. Accesses to different words complete together.

Reads return data in the cycle after the accepted strobe. Offsets not listed in the requirements read as zero and ignore writes. Only bit 0 of written data matters for the mailbox registers.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, the doorbell bits (net offset 0x00, host offset 0x20) and the enable bits (net 0x08, host 0x28) read 1. The net ready bit (net 0x0C) and the host reset bit (host 0x2C) read 0. The host_irq, net_irq, net_reset and n_wait outputs are low.
- R2: A net write to 0x00, 0x08 or 0x0C stores write-data bit 0 in that register. A later read returns it in bit 0, with all other bits 0, in the cycle after the read strobe.
- R3: host_irq is high exactly while the net doorbell bit is 0 and the host enable bit is 0. net_irq is high exactly while the host doorbell bit is 0 and the net enable bit is 0.
- R4: Net offset 0x04 reads the host doorbell bit, and host offset 0x24 reads the net doorbell bit. Writes to either offset change nothing.
- R5: Net offset 0x10 returns the REVISION parameter in bits 7:0, and writes to it are ignored.
- R6: Host offset 0x2C is a read/write bit, active high. net_reset follows it after exactly SYNC_STAGES clock edges.
- R7: Host offset 0x30 reads the net ready bit.
- R8: The shared store is seen at net byte offsets 0x2000 to 0x7FFF and host byte offsets 0x10000 to 0x15FFF. The word index is (offset minus window base) divided by 4, modulo 2^RAM_AW. A word written from either side reads back from the other.
- R9: When both sides access the same word index in one cycle, the host access completes. n_wait is high that cycle and the net access is not performed. When held into the next conflict-free cycle, it completes.
- R10: Same-cycle accesses from both sides to different word indices both complete, with n_wait low.
- R11: Addresses outside the listed registers and windows read 0, and writes to them change nothing, including the bytes just outside each window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| n_addr | input | NET_AW | Network-side byte address |
| n_wdata | input | DW | Network-side write data |
| n_rd | input | 1 | Network-side read strobe |
| n_wr | input | 1 | Network-side write strobe |
| n_rdata | output | DW | Network-side read data, valid the cycle after the strobe |
| n_wait | output | 1 | Network-side access not taken this cycle, hold it |
| h_addr | input | HOST_AW | Host-side byte address |
| h_wdata | input | DW | Host-side write data |
| h_rd | input | 1 | Host-side read strobe |
| h_wr | input | 1 | Host-side write strobe |
| h_rdata | output | DW | Host-side read data, valid the cycle after the strobe |
| host_irq | output | 1 | Interrupt toward the host, active high |
| net_irq | output | 1 | Interrupt toward the network controller, active high |
| net_reset | output | 1 | Re-timed reset toward the network controller, active high |

## Verification
The bench builds the bridge with RAM_AW=4, SYNC_STAGES=3 and REVISION=8'hC3. The 16-word store makes the top bytes of both windows and far-apart addresses land on the same word. This lets the bench check the modulo indexing and a collision between two different addresses that share an index. The three-stage re-timing chain makes the exact edge count of net_reset distinct from both the reset synchroniser and a single flop. The non-default revision shows that the read value comes from the parameter.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // network-side register offsets
  localparam logic [31:0] NOFF_DOOR = 32'h0000_0000;
  localparam logic [31:0] NOFF_INC  = 32'h0000_0004;
  localparam logic [31:0] NOFF_EN   = 32'h0000_0008;
  localparam logic [31:0] NOFF_RDY  = 32'h0000_000C;
  localparam logic [31:0] NOFF_REV  = 32'h0000_0010;

  // host-side register offsets
  localparam logic [31:0] HOFF_DOOR = 32'h0000_0020;
  localparam logic [31:0] HOFF_INC  = 32'h0000_0024;
  localparam logic [31:0] HOFF_EN   = 32'h0000_0028;
  localparam logic [31:0] HOFF_RST  = 32'h0000_002C;
  localparam logic [31:0] HOFF_RDY  = 32'h0000_0030;

  // shared store windows (inclusive bounds)
  localparam logic [31:0] NWIN_LO = 32'h0000_2000;
  localparam logic [31:0] NWIN_HI = 32'h0000_7FFF;
  localparam logic [31:0] HWIN_LO = 32'h0001_0000;
  localparam logic [31:0] HWIN_HI = 32'h0001_5FFF;

  typedef struct packed {
    logic ndoor;  // net -> host doorbell, active low
    logic nen;    // net enable of incoming, active low
    logic nrdy;   // net ready flag, active high
    logic hdoor;  // host -> net doorbell, active low
    logic hen;    // host enable of incoming, active low
    logic hrst;   // host-driven net reset, active high
  } mbx_bits_t;

  localparam mbx_bits_t MBX_BITS_RST = '{ndoor: 1'b1, nen: 1'b1, nrdy: 1'b0,
                                         hdoor: 1'b1, hen: 1'b1, hrst: 1'b0};

  function automatic logic in_win(input logic [31:0] a,
                                  input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] s;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic nxt;
      if (i == 0) begin : g_first
        assign nxt = d;
      end else begin : g_rest
        assign nxt = s[i-1];
      end
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) s[i] <= 1'b0;
        else        s[i] <= nxt;
      end
    end
  endgenerate

  assign q = s[STAGES-1];

endmodule

// File: rtl/mbx_arb.sv
module mbx_arb
  import mbx_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic [31:0]       n_a,
  input  logic              n_rd,
  input  logic              n_wr,
  input  logic [31:0]       h_a,
  input  logic              h_rd,
  input  logic              h_wr,
  output logic              n_hit,
  output logic              h_hit,
  output logic [RAM_AW-1:0] n_idx,
  output logic [RAM_AW-1:0] h_idx,
  output logic              n_go,
  output logic              h_go,
  output logic              n_wait
);

  logic n_req, h_req, same_word;

  always_comb begin
    n_hit     = in_win(n_a, NWIN_LO, NWIN_HI);
    h_hit     = in_win(h_a, HWIN_LO, HWIN_HI);
    n_idx     = n_a[RAM_AW+1:2] - NWIN_LO[RAM_AW+1:2];
    h_idx     = h_a[RAM_AW+1:2] - HWIN_LO[RAM_AW+1:2];
    n_req     = n_hit && (n_rd || n_wr);
    h_req     = h_hit && (h_rd || h_wr);
    same_word = (n_idx == h_idx);
    // host has priority on a same-word conflict
    n_wait    = n_req && h_req && same_word;
    h_go      = h_req;
    n_go      = n_req && !n_wait;
  end

endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int DW     = 32,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [RAM_AW-1:0] a_idx,
  input  logic [DW-1:0]     a_wd,
  output logic [DW-1:0]     a_q,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [RAM_AW-1:0] b_idx,
  input  logic [DW-1:0]     b_wd,
  output logic [DW-1:0]     b_q
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_idx] <= a_wd;
    if (b_en && b_we) mem[b_idx] <= b_wd;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_idx];
    if (b_en) b_q <= mem[b_idx];
  end

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int         DW       = 32,
  parameter logic [7:0] REVISION = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   n_a,
  input  logic          n_wr,
  input  logic          n_wd0,
  input  logic [31:0]   h_a,
  input  logic          h_wr,
  input  logic          h_wd0,
  output logic [DW-1:0] n_rv,
  output logic [DW-1:0] h_rv,
  output logic          host_irq,
  output logic          net_irq,
  output logic          hrst_bit
);

  localparam logic [DW-1:0] ZERO = '0;

  mbx_bits_t q, d;
  logic      en;

  // next state
  always_comb begin
    d  = q;
    en = n_wr || h_wr;
    if (n_wr && n_a == NOFF_DOOR) d.ndoor = n_wd0;
    if (n_wr && n_a == NOFF_EN)   d.nen   = n_wd0;
    if (n_wr && n_a == NOFF_RDY)  d.nrdy  = n_wd0;
    if (h_wr && h_a == HOFF_DOOR) d.hdoor = h_wd0;
    if (h_wr && h_a == HOFF_EN)   d.hen   = h_wd0;
    if (h_wr && h_a == HOFF_RST)  d.hrst  = h_wd0;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= MBX_BITS_RST;
    else if (en) q <= d;
  end

  // read muxes
  always_comb begin
    n_rv = ZERO;
    case (n_a)
      NOFF_DOOR: n_rv[0]   = q.ndoor;
      NOFF_INC:  n_rv[0]   = q.hdoor;
      NOFF_EN:   n_rv[0]   = q.nen;
      NOFF_RDY:  n_rv[0]   = q.nrdy;
      NOFF_REV:  n_rv[7:0] = REVISION;
      default:   n_rv      = ZERO;
    endcase
  end

  always_comb begin
    h_rv = ZERO;
    case (h_a)
      HOFF_DOOR: h_rv[0] = q.hdoor;
      HOFF_INC:  h_rv[0] = q.ndoor;
      HOFF_EN:   h_rv[0] = q.hen;
      HOFF_RST:  h_rv[0] = q.hrst;
      HOFF_RDY:  h_rv[0] = q.nrdy;
      default:   h_rv    = ZERO;
    endcase
  end

  assign host_irq = !q.ndoor && !q.hen;
  assign net_irq  = !q.hdoor && !q.nen;
  assign hrst_bit = q.hrst;

  // R2: doorbell and ready only move on their own write
  a_r2_door_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(n_wr && n_a == NOFF_DOOR) |=> $stable(q.ndoor));
  a_r2_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(n_wr && n_a == NOFF_RDY) |=> $stable(q.nrdy));
  // R4: incoming-view offset is read only
  a_r4_incoming_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (n_wr && n_a == NOFF_INC && !(h_wr && h_a == HOFF_DOOR)) |=> $stable(q.hdoor));
  // R3: an interrupt only starts when a doorbell or an enable drops
  a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> ($fell(q.ndoor) || $fell(q.hen)));
  // R6: reset bit only moves on a host write to its offset
  a_r6_rstbit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr && h_a == HOFF_RST) |=> $stable(q.hrst));

endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
  parameter int         DW          = 32,
  parameter int         NET_AW      = 15,
  parameter int         HOST_AW     = 17,
  parameter int         RAM_AW      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REVISION    = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NET_AW-1:0]  n_addr,
  input  logic [DW-1:0]      n_wdata,
  input  logic               n_rd,
  input  logic               n_wr,
  output logic [DW-1:0]      n_rdata,
  output logic               n_wait,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [DW-1:0]      h_wdata,
  input  logic               h_rd,
  input  logic               h_wr,
  output logic [DW-1:0]      h_rdata,
  output logic               host_irq,
  output logic               net_irq,
  output logic               net_reset
);

  localparam int RST_STAGES = 2;

  logic              rst_s;
  logic [31:0]       n_a32, h_a32;
  logic              n_hit, h_hit, n_go, h_go;
  logic [RAM_AW-1:0] n_idx, h_idx;
  logic [DW-1:0]     n_rv, h_rv, n_mq, h_mq;
  logic              hrst_bit;
  logic              n_acc, h_acc;
  logic              n_sel_q, h_sel_q;
  logic [DW-1:0]     n_reg_q, h_reg_q;

  assign n_a32 = {{(32-NET_AW){1'b0}}, n_addr};
  assign h_a32 = {{(32-HOST_AW){1'b0}}, h_addr};

  mbx_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .clr_n(rst_n), .d(1'b1), .q(rst_s));

  mbx_arb #(.RAM_AW(RAM_AW)) u_arb (
    .n_a(n_a32), .n_rd(n_rd), .n_wr(n_wr),
    .h_a(h_a32), .h_rd(h_rd), .h_wr(h_wr),
    .n_hit(n_hit), .h_hit(h_hit), .n_idx(n_idx), .h_idx(h_idx),
    .n_go(n_go), .h_go(h_go), .n_wait(n_wait));

  mbx_ram #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
    .clk(clk),
    .a_en(h_go), .a_we(h_wr), .a_idx(h_idx), .a_wd(h_wdata), .a_q(h_mq),
    .b_en(n_go), .b_we(n_wr), .b_idx(n_idx), .b_wd(n_wdata), .b_q(n_mq));

  mbx_regs #(.DW(DW), .REVISION(REVISION)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .n_a(n_a32), .n_wr(n_wr), .n_wd0(n_wdata[0]),
    .h_a(h_a32), .h_wr(h_wr), .h_wd0(h_wdata[0]),
    .n_rv(n_rv), .h_rv(h_rv),
    .host_irq(host_irq), .net_irq(net_irq), .hrst_bit(hrst_bit));

  mbx_sync #(.STAGES(SYNC_STAGES)) u_nrst_sync (
    .clk(clk), .clr_n(rst_s), .d(hrst_bit), .q(net_reset));

  // read return path: one registered stage per side
  assign n_acc = n_rd && !n_wait;
  assign h_acc = h_rd;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      n_sel_q <= 1'b0;
      n_reg_q <= '0;
    end else if (n_acc) begin
      n_sel_q <= n_hit;
      n_reg_q <= n_rv;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      h_sel_q <= 1'b0;
      h_reg_q <= '0;
    end else if (h_acc) begin
      h_sel_q <= h_hit;
      h_reg_q <= h_rv;
    end
  end

  assign n_rdata = n_sel_q ? n_mq : n_reg_q;
  assign h_rdata = h_sel_q ? h_mq : h_reg_q;

  // R9: the net side is only held off by a host access
  a_r9_wait_needs_host: assert property (@(posedge clk) disable iff (!rst_s)
    n_wait |-> (h_rd || h_wr));
  // R9: a held-off net access is never also issued to storage
  a_r9_wait_blocks_net: assert property (@(posedge clk) disable iff (!rst_s)
    n_wait |-> !n_go);

endmodule

// File: tb/sim_mbx_bridge.sv
module sim_mbx_bridge;

  localparam int         DW  = 32;
  localparam int         NAW = 15;
  localparam int         HAW = 17;
  localparam int         SS  = 3;
  localparam logic [7:0] REV = 8'hC3;

  logic           clk, rst_n;
  logic [NAW-1:0] n_addr;
  logic [DW-1:0]  n_wdata, n_rdata, h_wdata, h_rdata;
  logic           n_rd, n_wr, n_wait;
  logic [HAW-1:0] h_addr;
  logic           h_rd, h_wr, host_irq, net_irq, net_reset;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mbx_bridge #(.DW(DW), .NET_AW(NAW), .HOST_AW(HAW), .RAM_AW(4),
               .SYNC_STAGES(SS), .REVISION(REV)) u0 (
    .clk(clk), .rst_n(rst_n),
    .n_addr(n_addr), .n_wdata(n_wdata), .n_rd(n_rd), .n_wr(n_wr),
    .n_rdata(n_rdata), .n_wait(n_wait),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
    .h_rdata(h_rdata), .host_irq(host_irq), .net_irq(net_irq),
    .net_reset(net_reset));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        host;
    logic        wr;
    logic [16:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 35;
  // tags: R1 reset, R2/R4/R5/R7 registers, R8 windows, R11 unmapped
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 1'b0, 17'h00000, 32'h0, 32'h1},
    '{4'd1, 1'b0, 1'b0, 17'h00008, 32'h0, 32'h1},
    '{4'd1, 1'b0, 1'b0, 17'h0000C, 32'h0, 32'h0},
    '{4'd1, 1'b1, 1'b0, 17'h00020, 32'h0, 32'h1},
    '{4'd1, 1'b1, 1'b0, 17'h00028, 32'h0, 32'h1},
    '{4'd1, 1'b1, 1'b0, 17'h0002C, 32'h0, 32'h0},
    '{4'd5, 1'b0, 1'b0, 17'h00010, 32'h0, 32'h000000C3},
    '{4'd5, 1'b0, 1'b1, 17'h00010, 32'hFFFFFFFF, 32'h0},
    '{4'd5, 1'b0, 1'b0, 17'h00010, 32'h0, 32'h000000C3},
    '{4'd2, 1'b0, 1'b1, 17'h00000, 32'hFFFFFFFE, 32'h0},
    '{4'd2, 1'b0, 1'b0, 17'h00000, 32'h0, 32'h0},
    '{4'd4, 1'b1, 1'b0, 17'h00024, 32'h0, 32'h0},
    '{4'd2, 1'b0, 1'b1, 17'h0000C, 32'h00000003, 32'h0},
    '{4'd2, 1'b0, 1'b0, 17'h0000C, 32'h0, 32'h1},
    '{4'd7, 1'b1, 1'b0, 17'h00030, 32'h0, 32'h1},
    '{4'd4, 1'b0, 1'b1, 17'h00004, 32'h0, 32'h0},
    '{4'd4, 1'b1, 1'b0, 17'h00020, 32'h0, 32'h1},
    '{4'd4, 1'b0, 1'b0, 17'h00004, 32'h0, 32'h1},
    '{4'd8, 1'b0, 1'b1, 17'h02000, 32'hA5A50001, 32'h0},
    '{4'd8, 1'b1, 1'b0, 17'h10000, 32'h0, 32'hA5A50001},
    '{4'd8, 1'b1, 1'b1, 17'h1003C, 32'h12345678, 32'h0},
    '{4'd8, 1'b0, 1'b0, 17'h0203C, 32'h0, 32'h12345678},
    '{4'd8, 1'b0, 1'b0, 17'h0207C, 32'h0, 32'h12345678},
    '{4'd8, 1'b0, 1'b0, 17'h07FFC, 32'h0, 32'h12345678},
    '{4'd8, 1'b1, 1'b0, 17'h15FFC, 32'h0, 32'h12345678},
    '{4'd11, 1'b0, 1'b0, 17'h00014, 32'h0, 32'h0},
    '{4'd11, 1'b0, 1'b1, 17'h01000, 32'hFFFFFFFF, 32'h0},
    '{4'd11, 1'b0, 1'b0, 17'h01000, 32'h0, 32'h0},
    '{4'd11, 1'b0, 1'b0, 17'h02000, 32'h0, 32'hA5A50001},
    '{4'd11, 1'b1, 1'b1, 17'h16000, 32'hDEADBEEF, 32'h0},
    '{4'd11, 1'b1, 1'b0, 17'h16000, 32'h0, 32'h0},
    '{4'd11, 1'b1, 1'b0, 17'h10000, 32'h0, 32'hA5A50001},
    '{4'd11, 1'b1, 1'b0, 17'h0FFFC, 32'h0, 32'h0},
    '{4'd11, 1'b1, 1'b1, 17'h0FFFC, 32'h0BADF00D, 32'h0},
    '{4'd11, 1'b1, 1'b0, 17'h1003C, 32'h0, 32'h12345678}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    n_rd = 1'b0; n_wr = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
  endtask

  // one access on one side; read data sampled on the following negedge
  task automatic op(input logic host, input logic wr, input logic [16:0] a,
                    input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    if (host) begin
      h_addr = a; h_wdata = wd; h_wr = wr; h_rd = !wr;
    end else begin
      n_addr = a[NAW-1:0]; n_wdata = wd; n_wr = wr; n_rd = !wr;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    rd = host ? h_rdata : n_rdata;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; idle();
    n_addr = '0; h_addr = '0; n_wdata = '0; h_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
    chk("R1 net_irq", {31'b0, net_irq}, 32'h0);
    chk("R1 net_reset", {31'b0, net_reset}, 32'h0);
    chk("R1 n_wait", {31'b0, n_wait}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].host, VEC[i].wr, VEC[i].addr, VEC[i].wd, r);
      if (!VEC[i].wr)
        chk($sformatf("R%0d vec %0d", VEC[i].req, i), r, VEC[i].exp);
    end

    // R3 interrupt gating (net doorbell is 0 from the table)
    chk("R3 host_irq masked", {31'b0, host_irq}, 32'h0);
    op(1'b1, 1'b1, 17'h00028, 32'h0, r);
    chk("R3 host_irq enabled", {31'b0, host_irq}, 32'h1);
    op(1'b1, 1'b1, 17'h00020, 32'h0, r);
    chk("R3 net_irq masked", {31'b0, net_irq}, 32'h0);
    op(1'b0, 1'b1, 17'h00008, 32'h0, r);
    chk("R3 net_irq enabled", {31'b0, net_irq}, 32'h1);
    op(1'b0, 1'b1, 17'h00000, 32'h1, r);
    chk("R3 host_irq doorbell released", {31'b0, host_irq}, 32'h0);
    op(1'b0, 1'b0, 17'h00004, 32'h0, r);
    chk("R4 net sees host doorbell low", r, 32'h0);

    // R10 different words in one cycle
    @(negedge clk);
    n_addr = 15'h2014; n_wdata = 32'h55; n_wr = 1'b1;
    h_addr = 17'h10018; h_wdata = 32'h66; h_wr = 1'b1;
    #1 chk("R10 no wait", {31'b0, n_wait}, 32'h0);
    @(posedge clk);
    @(negedge clk) idle();
    op(1'b1, 1'b0, 17'h10014, 32'h0, r);
    chk("R10 net word", r, 32'h55);
    op(1'b0, 1'b0, 17'h02018, 32'h0, r);
    chk("R10 host word", r, 32'h66);

    // R9 same word, both write: host first, held net write lands after
    @(negedge clk);
    h_addr = 17'h1000C; h_wdata = 32'h1111; h_wr = 1'b1;
    n_addr = 15'h200C; n_wdata = 32'h2222; n_wr = 1'b1;
    #1 chk("R9 wait on conflict", {31'b0, n_wait}, 32'h1);
    @(posedge clk);
    @(negedge clk) h_wr = 1'b0;
    #1 chk("R9 wait released", {31'b0, n_wait}, 32'h0);
    @(posedge clk);
    @(negedge clk) idle();
    op(1'b1, 1'b0, 17'h1000C, 32'h0, r);
    chk("R9 held write lands last", r, 32'h2222);

    // R9 host read wins over a net write to the same word
    @(negedge clk);
    h_addr = 17'h1000C; h_rd = 1'b1;
    n_addr = 15'h200C; n_wdata = 32'h3333; n_wr = 1'b1;
    #1 chk("R9 wait read/write", {31'b0, n_wait}, 32'h1);
    @(posedge clk);
    @(negedge clk) h_rd = 1'b0;
    chk("R9 host read before net write", h_rdata, 32'h2222);
    @(posedge clk);
    @(negedge clk) idle();
    op(1'b0, 1'b0, 17'h0200C, 32'h0, r);
    chk("R9 net write done", r, 32'h3333);

    // R9 conflict through a mirrored address (0x204C -> word 3)
    @(negedge clk);
    h_addr = 17'h1000C; h_wdata = 32'h4444; h_wr = 1'b1;
    n_addr = 15'h204C; n_rd = 1'b1;
    #1 chk("R9 wait mirrored", {31'b0, n_wait}, 32'h1);
    @(posedge clk);
    @(negedge clk) h_wr = 1'b0;
    @(posedge clk);
    @(negedge clk) idle();
    chk("R9 held read sees host data", n_rdata, 32'h4444);

    // R6 reset bit and its re-timed output
    op(1'b1, 1'b1, 17'h0002C, 32'h1, r);
    chk("R6 net_reset edge 0", {31'b0, net_reset}, 32'h0);
    for (int k = 1; k <= SS; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R6 net_reset edge %0d", k), {31'b0, net_reset},
          (k == SS) ? 32'h1 : 32'h0);
    end
    op(1'b1, 1'b0, 17'h0002C, 32'h0, r);
    chk("R6 reset bit reads back", r, 32'h1);
    op(1'b1, 1'b1, 17'h0002C, 32'h0, r);
    repeat (SS) @(posedge clk);
    @(negedge clk);
    chk("R6 net_reset released", {31'b0, net_reset}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule